// File: doc/BRIEF.md
# Framed serial receive output port

This block sends one received TDM link toward the system side as a serial bit stream. It is a timing slave: the serial clock and the frame pulse both come from outside. The block takes them in through a synchronizer clocked by a faster core clock, turns them into per-edge strobes, and runs every register on that core clock. Each frame is made of channel bytes fetched from a frame buffer through a byte read port. The block drives the channel index, takes back that channel's data byte and its four signaling bits, and shifts them out, most significant bit first, on a data line and on a signaling line aligned with it.

Configuration inputs set which serial clock edge samples the frame pulse, which edge updates the outputs, the frame pulse polarity, the line format (24 channels plus one framing bit, or 32 channels), and whether the serial clock runs at twice the bit rate. At double rate a further select picks which of the two update edges in each bit drives the outputs. A period checker watches the spacing between frame pulses. A pulse that does not arrive on a frame boundary sets a sticky error flag, and that flag drives an interrupt when the interrupt is enabled.

Top module: `fsp_rx_port`

## Requirements
- R1: `ser_dat`, `ser_sig` and the frame position change only on an update edge of `ser_clk`: the rising edge when `cfg_dat_fall`=0, the falling edge when it is 1. No other edge changes them.
- R2: The frame pulse is sampled only on the `ser_clk` edge chosen by `cfg_fp_fall` (0 rising, 1 falling). It is active high when `cfg_fp_low`=0 and active low when it is 1. Only the first sampled edge on which the pulse is active starts a frame, so a pulse that stays active over several sampling edges counts once.
- R3: When the sampling edge and the update edge are the same, bit 0 of the frame is driven on the edge that samples the pulse. When they differ, the pulse is taken as leading, and bit 0 is driven on the next update edge.
- R4: With `cfg_e1`=1 a frame is 256 bits long: channels 0 to 31, eight bits each, MSB first. The channel being sent is shown on `rd_chan`.
- R5: With `cfg_e1`=0 a frame is 193 bits long. Bit 0 is bit 7 of the byte at channel index 0 (the framing bit). It is followed by channels 1 to 24, eight bits each, MSB first.
- R6: In each 8-bit channel slot, `ser_sig` is 0 during the first four bit times. During the last four it carries `rd_sig[3]`, `rd_sig[2]`, `rd_sig[1]` and `rd_sig[0]` of the same channel, in that order. It is 0 during the framing bit.
- R7: With `cfg_dbl`=1 each bit lasts two update edges. The outputs change on the first of the two when `cfg_dbl_sel`=0 and on the second when it is 1. The pulse-to-bit-0 alignment of R3 then applies to the first edge of bit 0.
- R8: After the first frame pulse following reset, every later pulse must start a frame exactly when the free-running frame count would wrap: 193 or 256 bits, doubled at double rate, or any multiple of that. Any other pulse sets `fp_err` and restarts the frame. Pulses on a multiple of the frame length, including skipped frames, leave `fp_err` unchanged.
- R9: `fp_err` stays set until a cycle with `err_clr`=1 clears it. A new error in the same cycle as a clear wins.
- R10: `irq` is high exactly when `fp_err` is set and `cfg_irq_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the serial clock and runs all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | External serial clock |
| fp_in | input | 1 | External frame pulse |
| cfg_fp_fall | input | 1 | Frame pulse sampling edge: 0 rising, 1 falling |
| cfg_dat_fall | input | 1 | Output update edge: 0 rising, 1 falling |
| cfg_e1 | input | 1 | Frame format: 0 for 193 bits, 1 for 256 bits |
| cfg_dbl | input | 1 | Serial clock at twice the bit rate |
| cfg_dbl_sel | input | 1 | At double rate: 0 updates on the first edge of a bit, 1 on the second |
| cfg_fp_low | input | 1 | Frame pulse active low when 1 |
| cfg_irq_en | input | 1 | Interrupt enable for the period error |
| err_clr | input | 1 | Clears the period error flag when 1 |
| rd_chan | output | 5 | Channel index presented to the frame buffer |
| rd_byte | input | 8 | Data byte of channel `rd_chan` |
| rd_sig | input | 4 | Signaling bits of channel `rd_chan` |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_sig | output | 1 | Serial signaling, aligned per channel with `ser_dat` |
| fp_err | output | 1 | Sticky frame pulse period error |
| irq | output | 1 | Interrupt request |

## Verification
A wrong frame position shows up on `ser_dat` within one bit time. It also skews the period check, so a frame pulse that is in fact correct raises `fp_err` at the next boundary. A wrong hold of a sampled pulse or a wrong pending start shifts the whole frame by one update edge, and every following bit then differs from the reference. The signaling line exposes a wrong slot phase within four bit times. The bench drives the ports, follows every serial edge with its own frame model, and compares data, signaling, error flag and interrupt after each edge settles.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int CH_W    = 5;   // channel index width
  localparam int BIT_W   = 3;   // bit-in-byte index width
  localparam int BYTE_W  = 1 << BIT_W;
  localparam int SIG_W   = 4;   // signaling bits per channel
  localparam int E1_LAST = 31;  // last channel, 256-bit frame
  localparam int T1_LAST = 24;  // last channel, 193-bit frame
endpackage

// File: rtl/fsp_edge_gen.sv
// Synchronises the serial clock and frame pulse, derives edge strobes and
// detects the first active sampling edge of each pulse.
module fsp_edge_gen #(
  parameter int SYNC_STAGES = 2   // must be 2 or more
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic fp_in,
  input  logic cfg_fp_fall,
  input  logic cfg_dat_fall,
  input  logic cfg_fp_low,
  output logic u_evt,
  output logic fp_hit
);
  logic [SYNC_STAGES-1:0] clk_sh_q, clk_sh_n;
  logic [SYNC_STAGES-1:0] fp_sh_q, fp_sh_n;
  logic clk_dly_q;
  logic fp_prev_q, fp_prev_n;
  logic sclk, rise, fall, s_evt, fp_act;

  assign sclk   = clk_sh_q[SYNC_STAGES-1];
  assign rise   = sclk & ~clk_dly_q;
  assign fall   = ~sclk & clk_dly_q;
  assign s_evt  = cfg_fp_fall  ? fall : rise;
  assign u_evt  = cfg_dat_fall ? fall : rise;
  assign fp_act = fp_sh_q[SYNC_STAGES-1] ^ cfg_fp_low;
  assign fp_hit = s_evt & fp_act & ~fp_prev_q;

  always_comb begin
    clk_sh_n  = {clk_sh_q[SYNC_STAGES-2:0], ser_clk};
    fp_sh_n   = {fp_sh_q[SYNC_STAGES-2:0], fp_in};
    fp_prev_n = s_evt ? fp_act : fp_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh_q  <= '0;
      fp_sh_q   <= '0;
      clk_dly_q <= 1'b0;
      fp_prev_q <= 1'b0;
    end else begin
      clk_sh_q  <= clk_sh_n;
      fp_sh_q   <= fp_sh_n;
      clk_dly_q <= sclk;
      fp_prev_q <= fp_prev_n;
    end
  end

  // R2: a held pulse never yields two starts in a row
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fp_hit |=> !fp_hit);
endmodule

// File: rtl/fsp_frame_ctr.sv
// Frame position counter, start alignment, double-rate phase and period check.
module fsp_frame_ctr
  import fsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             u_evt,
  input  logic             fp_hit,
  input  logic             cfg_e1,
  input  logic             cfg_dbl,
  input  logic             cfg_dbl_sel,
  input  logic             err_clr,
  output logic [CH_W-1:0]  rd_chan,
  output logic [BIT_W-1:0] bit_sel,
  output logic             upd,
  output logic             fp_err
);
  logic [CH_W-1:0]  chan_q, chan_n, last_ch;
  logic [BIT_W-1:0] bsel_q, bsel_n;
  logic hph_q, hph_n, pend_q, pend_n, seen_q, seen_n, err_q, err_n;
  logic at_end, wrap, err_set;

  assign last_ch = cfg_e1 ? CH_W'(E1_LAST) : CH_W'(T1_LAST);
  assign at_end  = (chan_q == last_ch) && (bsel_q == '0);
  assign wrap    = at_end && (!cfg_dbl || hph_q);

  always_comb begin
    chan_n  = chan_q;
    bsel_n  = bsel_q;
    hph_n   = hph_q;
    seen_n  = seen_q;
    err_set = 1'b0;
    pend_n  = u_evt ? 1'b0 : (pend_q | fp_hit);
    if (u_evt) begin
      if (pend_q || fp_hit) begin
        chan_n  = '0;
        bsel_n  = '1;
        hph_n   = 1'b0;
        seen_n  = 1'b1;
        err_set = seen_q && !wrap;
      end else if (cfg_dbl && !hph_q) begin
        hph_n = 1'b1;
      end else begin
        hph_n = 1'b0;
        if (at_end) begin
          chan_n = '0;
          bsel_n = '1;
        end else if ((bsel_q == '0) || (!cfg_e1 && chan_q == '0)) begin
          chan_n = chan_q + CH_W'(1);
          bsel_n = '1;
        end else begin
          bsel_n = bsel_q - BIT_W'(1);
        end
      end
    end
    err_n = err_set | (err_q & ~err_clr);
  end

  assign upd     = u_evt && (!cfg_dbl || (hph_n == cfg_dbl_sel));
  assign rd_chan = chan_n;
  assign bit_sel = bsel_n;
  assign fp_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      bsel_q <= '1;
      hph_q  <= 1'b0;
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      chan_q <= chan_n;
      bsel_q <= bsel_n;
      hph_q  <= hph_n;
      pend_q <= pend_n;
      seen_q <= seen_n;
      err_q  <= err_n;
    end
  end

  // R1: position moves only on an update edge
  a_r1_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !u_evt |=> ($stable(chan_q) && $stable(bsel_q)));
  // R9: flag holds until cleared
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
  // R8: an error is only raised by a frame start on an update edge
  a_r8_err_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(u_evt));
endmodule

// File: rtl/fsp_bit_out.sv
// Output registers for serial data and signaling.
module fsp_bit_out
  import fsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic [SIG_W-1:0]  rd_sig,
  output logic              ser_dat,
  output logic              ser_sig
);
  logic dat_q, dat_n, sig_q, sig_n, sig_bit;

  // signaling occupies the last four bit times of a slot (bit_sel 3..0)
  assign sig_bit = bit_sel[BIT_W-1] ? 1'b0 : rd_sig[bit_sel[1:0]];

  always_comb begin
    dat_n = upd ? rd_byte[bit_sel] : dat_q;
    sig_n = upd ? sig_bit          : sig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= 1'b0;
      sig_q <= 1'b0;
    end else begin
      dat_q <= dat_n;
      sig_q <= sig_n;
    end
  end

  assign ser_dat = dat_q;
  assign ser_sig = sig_q;

  // R1: outputs hold between update edges
  a_r1_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(ser_dat) && $stable(ser_sig)));
endmodule

// File: rtl/fsp_rx_port.sv
module fsp_rx_port
  import fsp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              fp_in,
  input  logic              cfg_fp_fall,
  input  logic              cfg_dat_fall,
  input  logic              cfg_e1,
  input  logic              cfg_dbl,
  input  logic              cfg_dbl_sel,
  input  logic              cfg_fp_low,
  input  logic              cfg_irq_en,
  input  logic              err_clr,
  output logic [CH_W-1:0]   rd_chan,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic [SIG_W-1:0]  rd_sig,
  output logic              ser_dat,
  output logic              ser_sig,
  output logic              fp_err,
  output logic              irq
);
  logic u_evt, fp_hit, upd;
  logic [BIT_W-1:0] bit_sel;

  fsp_edge_gen #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .fp_in(fp_in),
    .cfg_fp_fall(cfg_fp_fall), .cfg_dat_fall(cfg_dat_fall),
    .cfg_fp_low(cfg_fp_low), .u_evt(u_evt), .fp_hit(fp_hit)
  );

  fsp_frame_ctr i_ctr (
    .clk(clk), .rst_n(rst_n), .u_evt(u_evt), .fp_hit(fp_hit),
    .cfg_e1(cfg_e1), .cfg_dbl(cfg_dbl), .cfg_dbl_sel(cfg_dbl_sel),
    .err_clr(err_clr), .rd_chan(rd_chan), .bit_sel(bit_sel),
    .upd(upd), .fp_err(fp_err)
  );

  fsp_bit_out i_out (
    .clk(clk), .rst_n(rst_n), .upd(upd), .bit_sel(bit_sel),
    .rd_byte(rd_byte), .rd_sig(rd_sig),
    .ser_dat(ser_dat), .ser_sig(ser_sig)
  );

  assign irq = fp_err & cfg_irq_en;
endmodule

// File: tb/test_fsp_rx_port.sv
module test_fsp_rx_port;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ser_clk, fp_in, cfg_fp_fall, cfg_dat_fall, cfg_e1, cfg_dbl;
  logic cfg_dbl_sel, cfg_fp_low, cfg_irq_en, err_clr;
  logic [4:0] rd_chan;
  logic [7:0] rd_byte;
  logic [3:0] rd_sig;
  logic ser_dat, ser_sig, fp_err, irq;

  logic [7:0] mem [32];
  logic [3:0] smem [32];
  assign rd_byte = mem[rd_chan];
  assign rd_sig  = smem[rd_chan];

  fsp_rx_port i_fsp_rx_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .fp_in(fp_in),
    .cfg_fp_fall(cfg_fp_fall), .cfg_dat_fall(cfg_dat_fall), .cfg_e1(cfg_e1),
    .cfg_dbl(cfg_dbl), .cfg_dbl_sel(cfg_dbl_sel), .cfg_fp_low(cfg_fp_low),
    .cfg_irq_en(cfg_irq_en), .err_clr(err_clr), .rd_chan(rd_chan),
    .rd_byte(rd_byte), .rd_sig(rd_sig), .ser_dat(ser_dat), .ser_sig(ser_sig),
    .fp_err(fp_err), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  // reference model state
  int  pos, sidx;
  bit  pend, seen, prev, fp_lvl;
  logic exp_dat, exp_sig, exp_err;

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit fe, bit de, bit e1, bit dbl, bit sel, bit inv, bit en);
    @(negedge clk);
    rst_n = 1'b0; ser_clk = 1'b0; err_clr = 1'b0;
    cfg_fp_fall = fe; cfg_dat_fall = de; cfg_e1 = e1; cfg_dbl = dbl;
    cfg_dbl_sel = sel; cfg_fp_low = inv; cfg_irq_en = en;
    fp_in = inv; fp_lvl = 1'b0;
    pos = 0; sidx = 0; pend = 0; seen = 0; prev = 0;
    exp_dat = 1'b0; exp_sig = 1'b0; exp_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // one serial clock toggle with frame pulse level fpv (1 = active)
  task automatic step(bit fpv, string tag);
    bit rise, is_s, is_u, hit, upd, startf;
    int m, flen, b, ch, bp;
    @(negedge clk);
    ser_clk = ~ser_clk;
    fp_in   = fpv ^ cfg_fp_low;
    rise = ser_clk;
    is_s = cfg_fp_fall  ? !rise : rise;
    is_u = cfg_dat_fall ? !rise : rise;
    hit = 0; upd = 0; startf = 0;
    if (is_s) begin
      hit  = fpv && !prev;
      prev = fpv;
    end
    m    = cfg_dbl ? 2 : 1;
    flen = (cfg_e1 ? 256 : 193) * m;
    if (is_u) begin
      if (pend || hit) begin
        if (seen && pos != flen - 1) exp_err = 1'b1;
        seen = 1; pos = 0; startf = 1;
      end else begin
        pos = (pos + 1) % flen;
      end
      pend = 0;
      if (m == 1 || (pos % m) == int'(cfg_dbl_sel)) begin
        upd = 1;
        b = pos / m;
        if (cfg_e1) begin ch = b / 8; bp = 7 - (b % 8); end
        else if (b == 0) begin ch = 0; bp = 7; end
        else begin ch = (b - 1) / 8 + 1; bp = 7 - ((b - 1) % 8); end
        exp_dat = mem[ch][bp];
        exp_sig = (bp < 4) ? smem[ch][bp] : 1'b0;
      end
    end else if (hit) begin
      pend = 1;
    end
    repeat (3) @(negedge clk);
    chk(startf && upd ? "R3 first bit" : (upd ? tag : "R1 hold"), ser_dat, exp_dat);
    chk(upd ? "R6 signaling" : "R1 hold sig", ser_sig, exp_sig);
    chk("R8 period flag", fp_err, exp_err);
    chk("R10 irq", irq, exp_err & cfg_irq_en);
  endtask

  // toggles n times; pulse active on sampling edges where (sidx-phase)%period < width
  task automatic run(int n, int period, int phase, int width, string tag);
    for (int k = 0; k < n; k++) begin
      bit nrise, ns;
      nrise = !ser_clk;
      ns = cfg_fp_fall ? !nrise : nrise;
      if (ns) begin
        fp_lvl = (period > 0) && (sidx >= phase) && (((sidx - phase) % period) < width);
        sidx++;
      end
      step(fp_lvl, tag);
    end
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    exp_err = 1'b0;
    @(negedge clk);
    chk("R9 cleared", fp_err, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i]  = 8'((i * 37 + 11) ^ (i << 3));
      smem[i] = 4'(i * 5 + 3);
    end
    do_reset(0, 0, 1, 0, 0, 0, 1);
    chk("R1 reset data", ser_dat, 1'b0);
    chk("R6 reset sig", ser_sig, 1'b0);
    chk("R9 reset flag", fp_err, 1'b0);
    chk("R10 reset irq", irq, 1'b0);
    // R4: 32-channel frames, same sample and update edge
    run(2 * (3 * 256 + 10), 256, 3, 1, "R4 e1 data");
    // R2: falling-edge, active-low pulse leading a rising update edge
    do_reset(1, 0, 1, 0, 0, 1, 1);
    run(2 * (3 * 256 + 10), 256, 7, 1, "R2 edge/polarity data");
    // R5: 193-bit frames, rising sample, falling update
    do_reset(0, 1, 0, 0, 0, 0, 1);
    run(2 * (3 * 193 + 10), 193, 4, 1, "R5 t1 data");
    // R7: double rate, first edge updates
    do_reset(0, 0, 1, 1, 0, 0, 1);
    run(2 * (2 * 512 + 10), 512, 5, 1, "R7 dbl first");
    // R7 with second edge, wide pulse counted once (R2)
    do_reset(1, 1, 1, 1, 1, 0, 1);
    run(2 * (2 * 512 + 10), 512, 6, 2, "R7 dbl second");
    // R8 / R9 / R10: misplaced pulse
    do_reset(0, 0, 1, 0, 0, 0, 1);
    run(2 * 300, 256, 2, 1, "R8 before error");
    run(2 * 100, 256, 102, 1, "R8 misplaced");
    chk("R8 error raised", fp_err, 1'b1);
    chk("R10 irq raised", irq, 1'b1);
    run(2 * 20, 256, 102, 1, "R9 sticky");
    chk("R9 still set", fp_err, 1'b1);
    clear_err();
    run(2 * 600, 256, 102, 1, "R8 realigned");
    chk("R8 no new error", fp_err, 1'b0);
    @(negedge clk); cfg_irq_en = 1'b0;
    run(2 * 100, 256, 300, 1, "R10 masked");
    chk("R8 second error", fp_err, 1'b1);
    chk("R10 masked irq", irq, 1'b0);
    // R8: pulses every second frame are accepted
    do_reset(0, 0, 1, 0, 0, 0, 1);
    run(2 * 1100, 512, 9, 1, "R8 skipped frames");
    chk("R8 multiple ok", fp_err, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule